// File: doc/BRIEF.md
# Mode and System Control Register Block

This block is a small register file that sits on a byte-wide microcontroller peripheral bus. It holds three 8-bit registers. The first is a read-only mode register that reports the levels of three external mode-strap pins. The second is a read/write system control register. The third is a second system control register, present in one build variant and absent in the others. The individual control bits carry no meaning here: the block stores them and returns them on a read.

The mode-strap field is not sampled all the time. The pin levels are captured on the clock edge of a read of the mode register, and that captured value is also driven to the rest of the chip as the current operating mode. A power-on reset clears the captured value. A manual reset leaves it in place while it restores both control registers.

Bus accesses are single-cycle strobes with the low 16 address bits compared exactly. Read data is registered and holds its value between reads.

Top module: `modesys_regs`

## Requirements
- R1: After a power-on reset, `rdata` is 0x00 and `mode_q` is 0. A read of the system control register returns 0x01. A read of the second system control register returns 0x00 when it is present.
- R2: A read at address 0xFF3B returns the mode word. Bit 7 is 1, bits 6 to 3 are 0, and bits 2 to 0 equal `mode_pins` at the read edge, with bit n taken from pin n.
- R3: `mode_q` takes the value of `mode_pins` on the edge of a mode-register read and holds it at all other times, whatever the pins do.
- R4: A write to address 0xFF3B has no effect: `mode_q` and the other registers keep their values.
- R5: The system control register at 0xFF39 stores any byte written to it and returns that byte on a read.
- R6: When `SYS2_PRESENT` is 1, the register at 0xFF42 stores any byte written to it and returns that byte on a read.
- R7: When `SYS2_PRESENT` is 0, writes to 0xFF42 have no effect and reads of it return the constant `SYS2_FILL`.
- R8: `rdata` changes only on the clock edge of a read strobe, and shows the result from the next cycle onward. With no read strobe it holds its value.
- R9: A read at any other 16-bit address returns 0x00, even when only the high byte differs from a register address. A write to such an address changes no register.
- R10: A manual reset returns the system control register to 0x01, the second system control register to 0x00 and `rdata` to 0x00. It leaves `mode_q` unchanged.
- R11: A power-on reset clears `mode_q` to 0, including a value captured earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| addr | input | 16 | Low 16 bits of the access address |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle byte write strobe |
| wdata | input | 8 | Write data |
| mode_pins | input | 3 | Levels of the mode-strap pins |
| rdata | output | 8 | Registered read data |
| mode_q | output | 3 | Mode bits captured at the last mode-register read |

## Verification
The bench builds two copies of the block and drives them with the same stimulus. One copy has `SYS2_PRESENT` set to 1. The other has it set to 0, with `SYS2_FILL` set to 0xA5, a value that differs from both reset values. This lets a single pass compare the stored-byte behaviour of the second control register against the variant where that register is absent, whose writes are dropped and whose reads return the fill constant. All other parameters keep their defaults, so the address decode is tested against the real register addresses and against an address that differs from one of them only in the high byte.

// File: rtl/msr_pkg.sv
// Package: shared types for the mode/system control register block.
// Assumes: the three register selects are mutually exclusive.
package msr_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MODE = 2'd1,
        SEL_SYS  = 2'd2,
        SEL_SYS2 = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/msr_decode.sv
// Module: msr_decode
// Maps an access address to one register select by full-width compare.
// Assumes: the three register addresses are distinct.
module msr_decode
    import msr_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] MODE_ADDR = 16'hFF3B,
    parameter logic [15:0] SYS_ADDR  = 16'hFF39,
    parameter logic [15:0] SYS2_ADDR = 16'hFF42
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Purpose: compare every address bit against each register address.
    always_comb begin
        if (addr == ADDR_W'(MODE_ADDR))      sel = SEL_MODE;
        else if (addr == ADDR_W'(SYS_ADDR))  sel = SEL_SYS;
        else if (addr == ADDR_W'(SYS2_ADDR)) sel = SEL_SYS2;
        else                                 sel = SEL_NONE;
    end

endmodule

// File: rtl/msr_mode_latch.sv
// Module: msr_mode_latch
// Holds the mode-pin levels captured on a capture strobe.
// Assumes: only the power-on reset clears it; the manual reset is not wired in.
module msr_mode_latch #(
    parameter int PIN_W = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cap,
    input  logic [PIN_W-1:0] pins,
    output logic [PIN_W-1:0] lat
);

    // Purpose: clear on power-on, otherwise load the pins when cap is high.
    always_ff @(posedge clk) begin
        if (!por_n)   lat <= '0;
        else if (cap) lat <= pins;
    end

endmodule

// File: rtl/msr_ctrl_reg.sv
// Module: msr_ctrl_reg
// One byte control register, either built as storage or tied to a constant.
// Assumes: either reset returns the stored value to RST_VAL.
module msr_ctrl_reg #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0,
    parameter bit              PRESENT = 1'b1,
    parameter logic [W-1:0]    FILL    = '1
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         mrst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    generate
        if (PRESENT) begin : g_store
            logic [W-1:0] val;
            // Purpose: reset on either reset input, load on a write strobe.
            always_ff @(posedge clk) begin
                if (!por_n || !mrst_n) val <= RST_VAL;
                else if (we)           val <= wdata;
            end
            assign q = val;
        end else begin : g_absent
            logic unused_in;
            // Purpose: absent register; inputs are deliberately dropped.
            assign unused_in = ^{clk, por_n, mrst_n, we, wdata};
            assign q = FILL;
        end
    endgenerate

endmodule

// File: rtl/modesys_regs.sv
// Module: modesys_regs (top)
// Mode register plus two system control registers on a byte bus, with
// registered read data.
// Assumes: rd_en and wr_en are single-cycle strobes; both resets are
// synchronous and active low; power-on reset dominates.
module modesys_regs
    import msr_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 8,
    parameter int          PIN_W        = 3,
    parameter logic [15:0] MODE_ADDR    = 16'hFF3B,
    parameter logic [15:0] SYS_ADDR     = 16'hFF39,
    parameter logic [15:0] SYS2_ADDR    = 16'hFF42,
    parameter logic [7:0]  SYS_RST      = 8'h01,
    parameter logic [7:0]  SYS2_RST     = 8'h00,
    parameter bit          SYS2_PRESENT = 1'b1,
    parameter logic [7:0]  SYS2_FILL    = 8'hFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIN_W-1:0]  mode_pins,
    output logic [DATA_W-1:0] rdata,
    output logic [PIN_W-1:0]  mode_q
);

    localparam int PAD_W = DATA_W - 1 - PIN_W;

    reg_sel_e          sel;
    logic              mode_cap;
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] sys_q;
    logic [DATA_W-1:0] sys2_q;
    logic [DATA_W-1:0] rdata_q;

    msr_decode #(
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR),
        .SYS_ADDR (SYS_ADDR),
        .SYS2_ADDR(SYS2_ADDR)
    ) u_decode (
        .addr(addr),
        .sel (sel)
    );

    // Purpose: capture the pins only on a mode read outside any reset.
    assign mode_cap = rd_en && mrst_n && (sel == SEL_MODE);

    msr_mode_latch #(.PIN_W(PIN_W)) u_mode (
        .clk  (clk),
        .por_n(por_n),
        .cap  (mode_cap),
        .pins (mode_pins),
        .lat  (mode_q)
    );

    msr_ctrl_reg #(
        .W      (DATA_W),
        .RST_VAL(DATA_W'(SYS_RST)),
        .PRESENT(1'b1),
        .FILL   ('0)
    ) u_sys (
        .clk   (clk),
        .por_n (por_n),
        .mrst_n(mrst_n),
        .we    (wr_en && (sel == SEL_SYS)),
        .wdata (wdata),
        .q     (sys_q)
    );

    msr_ctrl_reg #(
        .W      (DATA_W),
        .RST_VAL(DATA_W'(SYS2_RST)),
        .PRESENT(SYS2_PRESENT),
        .FILL   (DATA_W'(SYS2_FILL))
    ) u_sys2 (
        .clk   (clk),
        .por_n (por_n),
        .mrst_n(mrst_n),
        .we    (wr_en && (sel == SEL_SYS2)),
        .wdata (wdata),
        .q     (sys2_q)
    );

    // Purpose: the mode word shows the pins being captured on this access.
    assign mode_word = {1'b1, {PAD_W{1'b0}}, mode_pins};

    // Purpose: register read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!por_n || !mrst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_MODE: rdata_q <= mode_word;
                SEL_SYS:  rdata_q <= sys_q;
                SEL_SYS2: rdata_q <= sys2_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/msr_checker.sv
// Module: msr_checker
// Temporal checks on the top-level ports, attached by bind.
// Assumes: attached to modesys_regs with matching parameters.
module msr_checker #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          PIN_W     = 3,
    parameter logic [15:0] MODE_ADDR = 16'hFF3B,
    parameter logic [15:0] SYS_ADDR  = 16'hFF39,
    parameter logic [15:0] SYS2_ADDR = 16'hFF42
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [PIN_W-1:0]  mode_pins,
    input logic [DATA_W-1:0] rdata,
    input logic [PIN_W-1:0]  mode_q
);

    localparam int PAD_W = DATA_W - 1 - PIN_W;

    logic live, mode_hit, other_hit;
    assign live      = por_n && mrst_n;
    assign mode_hit  = (addr == ADDR_W'(MODE_ADDR));
    assign other_hit = !mode_hit && (addr != ADDR_W'(SYS_ADDR))
                       && (addr != ADDR_W'(SYS2_ADDR));

    // R2
    mode_word_chk: assert property (@(posedge clk) disable iff (!live)
        (live && rd_en && mode_hit) |=>
            (rdata == {1'b1, {PAD_W{1'b0}}, $past(mode_pins)}));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!(rd_en && mode_hit)) |=> $stable(mode_q));

    // R4
    mode_wr_ign_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !rd_en && mode_hit) |=> $stable(mode_q));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!live)
        (live && !rd_en) |=> $stable(rdata));

    // R9
    unmatched_chk: assert property (@(posedge clk) disable iff (!live)
        (live && rd_en && other_hit) |=> (rdata == '0));

    // R10
    mrst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n) |=> $stable(mode_q));

    // R11
    por_clr_chk: assert property (@(posedge clk)
        (!por_n) |=> (mode_q == '0));

endmodule

bind modesys_regs msr_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PIN_W    (PIN_W),
    .MODE_ADDR(MODE_ADDR),
    .SYS_ADDR (SYS_ADDR),
    .SYS2_ADDR(SYS2_ADDR)
) u_msr_checker (
    .clk      (clk),
    .por_n    (por_n),
    .mrst_n   (mrst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .mode_pins(mode_pins),
    .rdata    (rdata),
    .mode_q   (mode_q)
);

// File: tb/modesys_regs_bench.sv
// Bench: directed tests, one task per scenario; two variants share stimulus.
module modesys_regs_bench;

    localparam logic [15:0] A_MODE = 16'hFF3B;
    localparam logic [15:0] A_SYS  = 16'hFF39;
    localparam logic [15:0] A_SYS2 = 16'hFF42;
    localparam logic [7:0]  FILL   = 8'hA5;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [2:0]  mode_pins = '0;
    logic [7:0]  rdata_a, rdata_b;
    logic [2:0]  mode_a, mode_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    modesys_regs #(.SYS2_PRESENT(1'b1)) u_modesys_regs (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .mode_pins(mode_pins), .rdata(rdata_a), .mode_q(mode_a)
    );

    modesys_regs #(.SYS2_PRESENT(1'b0), .SYS2_FILL(FILL)) u_modesys_regs_v0 (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .mode_pins(mode_pins), .rdata(rdata_b), .mode_q(mode_b)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read: strobe for one edge, sample at the following falling edge.
    task automatic bus_read(input logic [15:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_por();
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rdata", rdata_a, 8'h00);
        chk("R1 mode_q", {5'b0, mode_a}, 8'h00);
        bus_read(A_SYS);
        chk("R1 sys", rdata_a, 8'h01);
        bus_read(A_SYS2);
        chk("R1 sys2", rdata_a, 8'h00);
    endtask

    task automatic t_mode_read();
        mode_pins = 3'b101; bus_read(A_MODE);
        chk("R2 101", rdata_a, 8'h85);
        chk("R3 cap 101", {5'b0, mode_a}, 8'h05);
        mode_pins = 3'b010; bus_read(A_MODE);
        chk("R2 010", rdata_a, 8'h82);
        mode_pins = 3'b001; bus_read(A_MODE);
        chk("R2 001", rdata_a, 8'h81);
        chk("R3 cap 001", {5'b0, mode_a}, 8'h01);
    endtask

    task automatic t_mode_hold();
        mode_pins = 3'b111;
        repeat (3) @(negedge clk);
        chk("R3 hold", {5'b0, mode_a}, 8'h01);
        bus_write(A_MODE, 8'h00);
        chk("R4 wr mode_q", {5'b0, mode_a}, 8'h01);
        chk("R4 wr rdata", rdata_a, 8'h81);
    endtask

    task automatic t_sys();
        bus_write(A_SYS, 8'h5A); bus_read(A_SYS);
        chk("R5 5A", rdata_a, 8'h5A);
        bus_write(A_SYS, 8'hC3); bus_read(A_SYS);
        chk("R5 C3", rdata_a, 8'hC3);
    endtask

    task automatic t_sys2();
        bus_write(A_SYS2, 8'h3C); bus_read(A_SYS2);
        chk("R6 present", rdata_a, 8'h3C);
        chk("R7 absent", rdata_b, FILL);
        bus_read(A_SYS);
        chk("R6 sys kept", rdata_a, 8'hC3);
    endtask

    task automatic t_unmatched();
        bus_read(16'hFF40);
        chk("R9 FF40", rdata_a, 8'h00);
        bus_read(A_SYS);
        bus_read(16'hFE39);
        chk("R9 FE39", rdata_a, 8'h00);
        bus_write(16'hFF3A, 8'hFF);
        bus_write(16'hFE39, 8'h11);
        bus_read(A_SYS);
        chk("R9 no write", rdata_a, 8'hC3);
    endtask

    task automatic t_hold();
        bus_read(A_SYS2);
        addr = A_SYS;
        repeat (3) @(negedge clk);
        chk("R8 hold", rdata_a, 8'h3C);
        @(negedge clk); addr = A_MODE; rd_en = 1'b1;
        mode_pins = 3'b011;
        @(posedge clk); #1;
        chk("R8 edge", rdata_a, 8'h83);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_mrst();
        mode_pins = 3'b110; bus_read(A_MODE);
        chk("R10 pre", {5'b0, mode_a}, 8'h06);
        @(negedge clk); mrst_n = 1'b0; mode_pins = 3'b001;
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;
        chk("R10 mode kept", {5'b0, mode_a}, 8'h06);
        chk("R10 rdata", rdata_a, 8'h00);
        bus_read(A_SYS);
        chk("R10 sys", rdata_a, 8'h01);
        bus_read(A_SYS2);
        chk("R10 sys2", rdata_a, 8'h00);
    endtask

    task automatic t_por();
        pulse_por();
        chk("R11 mode clr", {5'b0, mode_a}, 8'h00);
        chk("R11 mode clr v0", {5'b0, mode_b}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset();
        t_mode_read();
        t_mode_hold();
        t_sys();
        t_sys2();
        t_unmatched();
        t_hold();
        t_mrst();
        t_por();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule